// File: doc/BRIEF.md
# Serial EEPROM Command and Write-Protect Controller

This block is the serial-peripheral slave front end of a 64 KiB byte-wide EEPROM. It receives instruction bytes on the serial pins and keeps the status byte. That byte holds the write-enable latch, two block-fence bits, the status-lock bit and the busy flag. The block decides whether a page program or a status update may go ahead and drives a byte-wide request port toward an external memory array. The serial pins are oversampled by the system clock through a synchronizer, so SCK must stay high and low for at least 8 clock cycles per phase.

A page program is collected into a 128-byte page buffer while it is being shifted in. When chip select rises, the buffer is replayed to the array inside a busy window of `WR_CYCLES` clock cycles that stands in for the nonvolatile write time. A read streams bytes from the array with the address auto-incrementing. A low-supply pulse input stands in for brown-out detection.

Top module: `spi_eeprom_ctrl`

## Requirements
- R1: After reset the status byte reads 00h, `so` is 0, no array request is issued, and the array content, which lives outside the block, reads back as FFh.
- R2: In both idle-low and idle-high SCK modes, SI is sampled on rising SCK and SO changes on falling SCK, MSB first. SO is 0 while chip select is high.
- R3: Opcode 05h returns the status byte: bit7 lock bit, bits 6..4 zero, bit3 fence-high, bit2 fence-low, bit1 write-enable latch, bit0 busy. The byte repeats for as long as clocks continue.
- R4: Only opcode 06h sets the write-enable latch and only 04h clears it by command. Each takes effect when chip select rises after a whole byte. Opcodes 02h and 01h have no effect while the latch is 0.
- R5: The write-enable latch clears when a program or status-update busy window ends, and on a `low_supply` pulse.
- R6: While the lock bit is 1 and `wp_n` is low, opcode 01h has no effect and the lock and fence bits hold.
- R7: Opcode 01h followed by a byte loads the lock bit from bit7 and the fence bits from bits 3:2, and starts a busy window.
- R8: Opcode 03h followed by a 16-bit address (MSB first) streams array bytes from that address. The address increments after each byte and wraps from FFFFh to 0000h.
- R9: Opcode 02h with an address and data bytes programs the page holding the address. The offset wraps inside the 128-byte page and a later byte replaces an earlier one at the same offset. Nothing is programmed unless chip select rises on a byte boundary.
- R10: Fence bits 01 protect C000h–FFFFh, 10 protect 8000h–FFFFh, 11 protect all, 00 none. A program aimed at a fenced page is ignored and leaves the latch set.
- R11: The busy flag stays 1 for `WR_CYCLES` cycles after an accepted program or status update. While busy, every opcode except 05h is ignored.
- R12: An unknown opcode makes the block ignore the remaining bytes until chip select rises.
- R13: Array writes happen only inside the busy window and stay within one page. Read data is taken one cycle after `mem_rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| wp_n | input | 1 | Write-protect pin, active low |
| low_supply | input | 1 | One-cycle low-supply indication |
| so | output | 1 | Serial data out |
| mem_rd_en | output | 1 | Array read request |
| mem_wr_en | output | 1 | Array write request |
| mem_addr | output | 16 | Array byte address |
| mem_wdata | output | 8 | Array write data |
| mem_rdata | input | 8 | Array read data, valid the cycle after `mem_rd_en` |

## Verification
SO moves about three clock cycles after an SCK falling edge has passed the synchronizer. The bench drives each SCK phase for 8 cycles and samples SO just before the next rising edge, long after it has settled. Read data for a byte is fetched within about five cycles of the rising edge that completes the previous byte, ahead of the falling edge that presents it. Instruction commits take effect a few cycles after chip select rises. The bench holds chip select high for 8 cycles before the next transaction and judges busy-window length by polling the status byte at fixed offsets before and after `WR_CYCLES`.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_WRSR, CMD_WRITE, CMD_READ, CMD_WRDI, CMD_RDSR, CMD_WREN
  } cmd_e;

  localparam logic [7:0] OP_SETSR = 8'h01;
  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WDIS  = 8'h04;
  localparam logic [7:0] OP_GETSR = 8'h05;
  localparam logic [7:0] OP_WEN   = 8'h06;

  // Opcode decode; while busy only the status read survives.
  function automatic cmd_e decode_op(input logic [7:0] op, input logic busy);
    cmd_e c;
    case (op)
      OP_SETSR: c = CMD_WRSR;
      OP_PROG:  c = CMD_WRITE;
      OP_READ:  c = CMD_READ;
      OP_WDIS:  c = CMD_WRDI;
      OP_GETSR: c = CMD_RDSR;
      OP_WEN:   c = CMD_WREN;
      default:  c = CMD_NONE;
    endcase
    if (busy && c != CMD_RDSR) c = CMD_NONE;
    return c;
  endfunction

  // Fenced region test on the two top address bits.
  function automatic logic in_fence(input logic [1:0] bp, input logic [1:0] top2);
    case (bp)
      2'b00:   return 1'b0;
      2'b01:   return top2 == 2'b11;
      2'b10:   return top2[1];
      default: return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/spi_ee_sync.sv
module spi_ee_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) stg <= {STAGES{RST_VAL}};
    else     stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_ee_pagebuf.sv
module spi_ee_pagebuf #(
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
    rdata <= ram[raddr];
  end
endmodule

// File: rtl/spi_ee_status.sv
module spi_ee_status #(
  parameter int WR_CYCLES = 1500
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       set_wel,
  input  logic       clr_wel,
  input  logic       low_supply,
  input  logic       sr_load,
  input  logic [2:0] sr_din,     // {lock, fence[1:0]}
  input  logic       cyc_start,
  input  logic       lock,
  output logic [7:0] status,
  output logic       wip,
  output logic       srwd,
  output logic [1:0] bp
);
  localparam int TW = $clog2(WR_CYCLES + 1);

  logic [TW-1:0] tmr;
  logic          wel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr   <= '0;
      wel_q <= 1'b0;
      srwd  <= 1'b0;
      bp    <= 2'b00;
    end else begin
      if (cyc_start)      tmr <= TW'(WR_CYCLES);
      else if (tmr != 0)  tmr <= tmr - 1'b1;
      if (sr_load) begin
        srwd <= sr_din[2];
        bp   <= sr_din[1:0];
      end
      if (low_supply || clr_wel || tmr == TW'(1)) wel_q <= 1'b0;
      else if (set_wel)                          wel_q <= 1'b1;
    end
  end

  assign wip    = (tmr != 0);
  assign status = {srwd, 3'b000, bp, wel_q, wip};

  // R6: locked state keeps the nonvolatile bits frozen
  p_lock_holds_r6: assert property (@(posedge clk) disable iff (rst)
    lock |=> $stable({srwd, bp}));
  // R4: a busy window opens only with the latch set
  p_cycle_needs_wel_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(wip) |-> $past(wel_q));
  // R5: latch is clear once the busy window closes
  p_wel_cleared_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(wip) |-> !wel_q);
endmodule

// File: rtl/spi_eeprom_ctrl.sv
module spi_eeprom_ctrl
  import spi_ee_pkg::*;
#(
  parameter int PAGE_BYTES = 128,
  parameter int WR_CYCLES  = 1500
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cs_n,
  input  logic        sck,
  input  logic        si,
  input  logic        wp_n,
  input  logic        low_supply,
  output logic        so,
  output logic        mem_rd_en,
  output logic        mem_wr_en,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata
);
  localparam int ADDR_W = 16;
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int CNT_W  = OFF_W + 1;
  localparam int PG_W   = ADDR_W - OFF_W;

  logic cs_n_s, sck_s, si_s, wp_n_s;
  spi_ee_sync #(.W(4), .STAGES(2), .RST_VAL(4'b1001)) u_sync (
    .clk(clk), .rst(rst), .d({cs_n, sck, si, wp_n}), .q({cs_n_s, sck_s, si_s, wp_n_s}));

  logic sck_d, sel_d;
  logic sel, start, finish, rise, fall;
  assign sel    = ~cs_n_s;
  assign start  = sel & ~sel_d;
  assign finish = ~sel & sel_d;
  assign rise   = sel & sck_s & ~sck_d;
  assign fall   = sel & ~sck_s & sck_d;

  cmd_e              cmd;
  logic [7:0]        rx, tx, addr_hi, rd_byte;
  logic [7:0]        rx_next, src;
  logic [2:0]        bitcnt;
  logic [1:0]        bytecnt;   // complete bytes, saturating at 3
  logic [2:0]        sr_val;
  logic [PG_W-1:0]   page_q, cm_page;
  logic [OFF_W-1:0]  wptr, start_off, cm_ptr;
  logic [CNT_W-1:0]  bytes_in, cm_left;
  logic [ADDR_W-1:0] full_addr, pend_addr;
  logic              pend, rd_v, out_phase;

  assign rx_next   = {rx[6:0], si_s};
  assign full_addr = {addr_hi, rx_next};

  // Status register and busy timer
  logic [7:0] status;
  logic       wip, srwd, wel;
  logic [1:0] bp;
  logic       hw_lock, fin_ok, do_wren, do_wrdi, do_wrsr, do_write;

  assign wel     = status[1];
  assign hw_lock = srwd & ~wp_n_s;
  assign fin_ok  = finish && bitcnt == 3'd0;
  assign do_wren = fin_ok && cmd == CMD_WREN && bytecnt != 2'd0;
  assign do_wrdi = fin_ok && cmd == CMD_WRDI && bytecnt != 2'd0;
  assign do_wrsr = fin_ok && cmd == CMD_WRSR && bytecnt >= 2'd2 && wel && !hw_lock;
  assign do_write = fin_ok && cmd == CMD_WRITE && bytes_in != '0 && wel &&
                    !in_fence(bp, page_q[PG_W-1 -: 2]);

  spi_ee_status #(.WR_CYCLES(WR_CYCLES)) u_status (
    .clk(clk), .rst(rst), .set_wel(do_wren), .clr_wel(do_wrdi),
    .low_supply(low_supply), .sr_load(do_wrsr), .sr_din(sr_val),
    .cyc_start(do_wrsr | do_write), .lock(hw_lock),
    .status(status), .wip(wip), .srwd(srwd), .bp(bp));

  // Page buffer
  logic       buf_we;
  logic [7:0] buf_q;
  assign buf_we = rise && bitcnt == 3'd7 && cmd == CMD_WRITE && bytecnt == 2'd3;

  spi_ee_pagebuf #(.DEPTH(PAGE_BYTES)) u_buf (
    .clk(clk), .we(buf_we), .waddr(wptr), .wdata(rx_next),
    .raddr(cm_ptr), .rdata(buf_q));

  assign out_phase = (cmd == CMD_READ && bytecnt == 2'd3) ||
                     (cmd == CMD_RDSR && bytecnt != 2'd0);
  assign src = (cmd == CMD_READ) ? rd_byte : status;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d <= 1'b0;  sel_d <= 1'b0;  rd_v <= 1'b0;  rd_byte <= 8'h00;
      mem_rd_en <= 1'b0;  mem_wr_en <= 1'b0;  mem_addr <= '0;  mem_wdata <= 8'h00;
      pend <= 1'b0;  pend_addr <= '0;  cm_left <= '0;  cm_ptr <= '0;  cm_page <= '0;
      bitcnt <= '0;  bytecnt <= '0;  cmd <= CMD_NONE;  bytes_in <= '0;
      rx <= 8'h00;  tx <= 8'h00;  so <= 1'b0;  addr_hi <= 8'h00;  sr_val <= '0;
      page_q <= '0;  wptr <= '0;  start_off <= '0;
    end else begin
      sck_d <= sck_s;
      sel_d <= sel;
      rd_v  <= mem_rd_en;
      if (rd_v) rd_byte <= mem_rdata;

      // Commit replay: buffer read, then array write one cycle later
      mem_rd_en <= 1'b0;
      mem_wr_en <= pend;
      mem_wdata <= buf_q;
      if (pend) mem_addr <= pend_addr;
      pend <= 1'b0;
      if (cm_left != '0) begin
        pend      <= 1'b1;
        pend_addr <= {cm_page, cm_ptr};
        cm_ptr    <= cm_ptr + 1'b1;
        cm_left   <= cm_left - 1'b1;
      end
      if (do_write) begin
        cm_left <= bytes_in;
        cm_ptr  <= start_off;
        cm_page <= page_q;
      end

      // Serial receive and byte decode
      if (start) begin
        bitcnt   <= '0;
        bytecnt  <= '0;
        cmd      <= CMD_NONE;
        bytes_in <= '0;
      end else if (rise) begin
        rx     <= rx_next;
        bitcnt <= bitcnt + 1'b1;
        if (bitcnt == 3'd7) begin
          if (bytecnt != 2'd3) bytecnt <= bytecnt + 1'b1;
          case (bytecnt)
            2'd0: cmd <= decode_op(rx_next, wip);
            2'd1: begin
              addr_hi <= rx_next;
              sr_val  <= {rx_next[7], rx_next[3:2]};
            end
            2'd2: begin
              page_q    <= full_addr[ADDR_W-1:OFF_W];
              wptr      <= full_addr[OFF_W-1:0];
              start_off <= full_addr[OFF_W-1:0];
              if (cmd == CMD_READ) begin
                mem_rd_en <= 1'b1;
                mem_addr  <= full_addr;
              end
            end
            default: begin
              if (cmd == CMD_READ) begin
                mem_rd_en <= 1'b1;
                mem_addr  <= mem_addr + 1'b1;
              end
              if (cmd == CMD_WRITE) begin
                wptr <= wptr + 1'b1;
                if (bytes_in != CNT_W'(PAGE_BYTES)) bytes_in <= bytes_in + 1'b1;
              end
            end
          endcase
        end
      end

      // Serial transmit
      if (!sel) begin
        so <= 1'b0;
      end else if (fall) begin
        if (!out_phase) begin
          so <= 1'b0;
        end else if (bitcnt == 3'd0) begin
          so <= src[7];
          tx <= {src[6:0], 1'b0};
        end else begin
          so <= tx[7];
          tx <= {tx[6:0], 1'b0};
        end
      end
    end
  end

  // R2: output quiet while deselected
  p_so_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !sel |=> !so);
  // R11: no array read while busy
  p_no_read_busy_r11: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> !wip);
  // R13: array writes only inside the busy window
  p_write_in_window_r13: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> wip);
  // R9: a replay burst stays in one page
  p_same_page_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_en && $past(mem_wr_en)) |-> mem_addr[ADDR_W-1:OFF_W] == $past(mem_addr[ADDR_W-1:OFF_W]));
  // R10: no write lands in a fenced region
  p_fence_respected_r10: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> !in_fence(bp, mem_addr[ADDR_W-1 -: 2]));
endmodule

// File: tb/spi_eeprom_ctrl_test.sv
module spi_eeprom_ctrl_test;
  localparam int HALF = 8;
  localparam int WRC  = 1500;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, cs_n = 1'b1, sck = 1'b0, si = 1'b0, wp_n = 1'b1, low_supply = 1'b0;
  logic so, mem_rd_en, mem_wr_en;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;

  spi_eeprom_ctrl #(.PAGE_BYTES(128), .WR_CYCLES(WRC)) uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si), .wp_n(wp_n),
    .low_supply(low_supply), .so(so), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  // Array model (erased = FFh), synchronous read
  logic [7:0] arr [logic [15:0]];
  logic [7:0] exp_mem [logic [15:0]];
  always @(posedge clk) begin
    if (mem_wr_en) arr[mem_addr] = mem_wdata;
    if (mem_rd_en) mem_rdata <= arr.exists(mem_addr) ? arr[mem_addr] : 8'hFF;
  end

  int checks = 0, fails = 0;
  bit mode3 = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  function automatic logic [7:0] exp_rd(input logic [15:0] a);
    return exp_mem.exists(a) ? exp_mem[a] : 8'hFF;
  endfunction

  function automatic logic [7:0] pat(input logic [7:0] s, input int i);
    return s ^ 8'(i * 37) ^ 8'h5A;
  endfunction

  function automatic bit fenced(input logic [1:0] bp, input logic [15:0] a);
    case (bp)
      2'b00: return 1'b0;
      2'b01: return a >= 16'hC000;
      2'b10: return a >= 16'h8000;
      default: return 1'b1;
    endcase
  endfunction

  task automatic xbits(input logic [7:0] d, input int nb, output logic [7:0] r);
    r = 8'h00;
    for (int i = 7; i > 7 - nb; i--) begin
      if (mode3) sck = 1'b0;
      si = d[i];
      tick(HALF);
      r[i] = so;
      sck = 1'b1;
      tick(HALF);
      if (!mode3) sck = 1'b0;
    end
  endtask

  task automatic xbyte(input logic [7:0] d, output logic [7:0] r);
    xbits(d, 8, r);
  endtask

  task automatic sel_on();
    sck = mode3;
    tick(4);
    cs_n = 1'b0;
    tick(HALF);
  endtask

  task automatic sel_off();
    tick(HALF);
    cs_n = 1'b1;
    tick(HALF);
  endtask

  task automatic op1(input logic [7:0] op);
    logic [7:0] r;
    sel_on(); xbyte(op, r); sel_off();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] r;
    sel_on(); xbyte(8'h05, r); xbyte(8'h00, s); sel_off();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] r;
    sel_on(); xbyte(8'h01, r); xbyte(v, r); sel_off();
  endtask

  task automatic wr_page(input logic [15:0] a, input int n, input logic [7:0] sd);
    logic [7:0] r;
    sel_on(); xbyte(8'h02, r); xbyte(a[15:8], r); xbyte(a[7:0], r);
    for (int i = 0; i < n; i++) xbyte(pat(sd, i), r);
    sel_off();
  endtask

  task automatic exp_write(input logic [15:0] a, input int n, input logic [7:0] sd);
    for (int i = 0; i < n; i++) exp_mem[{a[15:7], 7'(a[6:0] + 7'(i))}] = pat(sd, i);
  endtask

  task automatic rd_check(input logic [15:0] a, input int n, input string tag);
    logic [7:0] r;
    sel_on(); xbyte(8'h03, r); xbyte(a[15:8], r); xbyte(a[7:0], r);
    for (int i = 0; i < n; i++) begin
      xbyte(8'h00, r);
      chk(r == exp_rd(a + 16'(i)), tag, r, exp_rd(a + 16'(i)));
    end
    sel_off();
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int k = 0; k < 40; k++) begin
      rdsr(s);
      if (!s[0]) break;
      tick(64);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=%h exp=%h", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] s, s2, r;
    logic [15:0] a;
    logic [1:0] cur_bp;
    void'($urandom(32'd4242));
    tick(5);
    rst = 1'b0;
    tick(3);

    // R1: reset state
    chk(so == 1'b0 && !mem_rd_en && !mem_wr_en, "R1 idle ports", {so, mem_rd_en, mem_wr_en}, 0);
    rdsr(s);
    chk(s == 8'h00, "R1 R3 status after reset", s, 8'h00);
    rd_check(16'h1234, 2, "R1 R8 erased read");

    // R4: rejected without latch, then set/clear
    wr_page(16'h0010, 1, 8'h11);
    rdsr(s);
    chk(s == 8'h00, "R4 write without latch", s, 8'h00);
    rd_check(16'h0010, 1, "R4 no program");
    op1(8'h06); rdsr(s);
    chk(s == 8'h02, "R4 latch set", s, 8'h02);
    op1(8'h04); rdsr(s);
    chk(s == 8'h00, "R4 latch cleared", s, 8'h00);

    // R11: busy window and R9 program
    op1(8'h06);
    wr_page(16'h0100, 3, 8'h21);
    exp_write(16'h0100, 3, 8'h21);
    rdsr(s);
    chk(s == 8'h03, "R11 busy after program", s, 8'h03);
    sel_on(); xbyte(8'h03, r); xbyte(8'h01, r); xbyte(8'h00, r); xbyte(8'h00, r); sel_off();
    chk(r == 8'h00, "R11 read ignored while busy", r, 8'h00);
    op1(8'h06); rdsr(s);
    chk(s == 8'h03, "R11 latch cmd ignored while busy", s, 8'h03);
    tick(WRC);
    rdsr(s);
    chk(s == 8'h00, "R5 R11 window over latch clear", s, 8'h00);
    rd_check(16'h0100, 3, "R9 programmed bytes");

    // R9: wrap inside page, overflow beyond 128
    op1(8'h06); wr_page(16'h027E, 4, 8'h33); exp_write(16'h027E, 4, 8'h33); wait_idle();
    rd_check(16'h0200, 2, "R9 page wrap low");
    rd_check(16'h027E, 2, "R9 page wrap high");
    op1(8'h06); wr_page(16'h0300, 130, 8'h44); exp_write(16'h0300, 130, 8'h44); wait_idle();
    rd_check(16'h0300, 3, "R9 overflow replaces");
    rd_check(16'h037F, 1, "R9 overflow last");

    // R9: partial byte at deselect
    op1(8'h06);
    sel_on(); xbyte(8'h02, r); xbyte(8'h00, r); xbyte(8'h50, r); xbyte(8'h77, r);
    xbits(8'hE0, 3, r); sel_off();
    rdsr(s);
    chk(s == 8'h02, "R9 no commit off boundary", s, 8'h02);
    rd_check(16'h0050, 1, "R9 array untouched");
    op1(8'h04);

    // R12: unknown opcode swallows the rest
    sel_on(); xbyte(8'hAB, r); xbyte(8'h06, r); sel_off();
    rdsr(s);
    chk(s == 8'h00, "R12 unknown opcode", s, 8'h00);

    // R5: low supply
    op1(8'h06);
    low_supply = 1'b1; tick(1); low_supply = 1'b0;
    rdsr(s);
    chk(s == 8'h00, "R5 low supply clears latch", s, 8'h00);

    // R3: repeated status
    op1(8'h06);
    sel_on(); xbyte(8'h05, r); xbyte(8'h00, s); xbyte(8'h00, s2); sel_off();
    chk(s == 8'h02 && s2 == 8'h02, "R3 status repeats", {s, s2}, 16'h0202);
    op1(8'h04);

    // R2: idle-high clock mode
    mode3 = 1'b1;
    rdsr(s);
    chk(s == 8'h00, "R2 mode3 status", s, 8'h00);
    rd_check(16'h0100, 3, "R2 mode3 read");
    mode3 = 1'b0;

    // R8: wrap at top of array
    op1(8'h06); wr_page(16'hFFFF, 2, 8'h55); exp_write(16'hFFFF, 2, 8'h55); wait_idle();
    rd_check(16'hFFFF, 2, "R8 address wrap");

    // R10: quarter fence
    op1(8'h06); wrsr(8'h04); wait_idle();
    rdsr(s);
    chk(s == 8'h04, "R7 fence bits loaded", s, 8'h04);
    op1(8'h06); wr_page(16'hC000, 1, 8'h66); rdsr(s);
    chk(s == 8'h06, "R10 fenced program ignored", s, 8'h06);
    wr_page(16'hBF80, 1, 8'h67); exp_write(16'hBF80, 1, 8'h67); rdsr(s);
    chk(s == 8'h07, "R10 unfenced program accepted", s, 8'h07);
    wait_idle();
    rd_check(16'hC000, 1, "R10 fenced byte erased");
    rd_check(16'hBF80, 1, "R10 open byte written");

    // R7, R6: lock bit with write-protect pin
    op1(8'h06); wrsr(8'h8C); wait_idle();
    rdsr(s);
    chk(s == 8'h8C, "R7 status update", s, 8'h8C);
    op1(8'h06); wr_page(16'h0000, 1, 8'h77); rdsr(s);
    chk(s == 8'h8E, "R10 full fence", s, 8'h8E);
    wp_n = 1'b0;
    wrsr(8'h00); rdsr(s);
    chk(s == 8'h8E, "R6 locked update ignored", s, 8'h8E);
    wp_n = 1'b1;
    wrsr(8'h00); rdsr(s);
    chk(s == 8'h03, "R6 unlocked update accepted", s, 8'h03);
    wait_idle(); rdsr(s);
    chk(s == 8'h00, "R5 latch clear after update", s, 8'h00);

    // Random programs against random fences
    cur_bp = 2'b00;
    for (int k = 0; k < 12; k++) begin
      int n;
      logic [7:0] sd;
      if (k % 4 == 3) begin
        cur_bp = 2'($urandom_range(0, 3));
        op1(8'h06); wrsr({4'b0000, cur_bp, 2'b00}); wait_idle();
      end
      a  = 16'($urandom);
      n  = $urandom_range(1, 6);
      sd = 8'($urandom);
      op1(8'h06);
      wr_page(a, n, sd);
      rdsr(s);
      if (fenced(cur_bp, a)) begin
        chk(s == {4'b0000, cur_bp, 2'b10}, "R10 random fenced", s, {4'b0000, cur_bp, 2'b10});
        op1(8'h04);
      end else begin
        exp_write(a, n, sd);
        chk(s == {4'b0000, cur_bp, 2'b11}, "R9 random accepted", s, {4'b0000, cur_bp, 2'b11});
        wait_idle();
      end
      rd_check(a, n, "R9 R13 random readback");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule